// File: doc/BRIEF.md
# DS1 Receive Alarm Detector

This block watches a recovered DS1 receive bit stream, one bit per clock, and raises three line alarm indications. The first is the remote (yellow) alarm, signalled by a zero in the second bit of every DS0 channel. The second is the extended-superframe yellow alarm, signalled by a repeating run of eight ones then eight zeros on the facility data link. The third is the blue alarm, signalled by an unframed all-ones stream.

The framer supplies these inputs alongside each bit: a frame-start strobe, the DS0 channel and bit indices, an out-of-frame flag, an extended-superframe mode select and a strobe that marks data-link bits. The block counts its own 250 us windows from frame strobes, two frames to a window. All outputs are registered levels.

Top module: `ds1_rx_alarm_det`

## Requirements
- R1: After reset, yellow_o, esf_yellow_o and blue_o are all 0.
- R2: A frame is the run of bits from one frame_start_i cycle up to the cycle before the next one. The frame_start_i cycle carries the framing bit and is not a channel bit. If all 24 channels (chan_idx_i 0..23) of a frame carry 0 at bit_idx_i == 1, yellow_o is 1 from the edge that samples the next frame_start_i.
- R3: If any channel bit at bit_idx_i == 1 within a frame is 1, yellow_o is 0 from the edge that samples the next frame_start_i.
- R4: A frame that holds fewer than 24 samples at bit_idx_i == 1, all of them 0, leaves yellow_o unchanged.
- R5: With esf_mode_i high, esf_yellow_o is set at the edge that samples a data-link bit (fdl_valid_i high) completing the sequence of eight 1s followed by eight 0s, oldest bit first.
- R6: Once set, esf_yellow_o holds while the pattern keeps repeating. It clears on the 16th consecutive data-link bit after which the last 16 data-link bits do not form the pattern.
- R7: While esf_mode_i is low, esf_yellow_o is 0 from the next edge, and data-link bits are discarded.
- R8: Cycles with fdl_valid_i low do not change esf_yellow_o or the pattern history.
- R9: blue_o is set at the frame_start_i edge that ends the second consecutive frame in which every bit, the framing bit included, was 1 and oof_i was high in every cycle.
- R10: All-ones frames received while oof_i is low do not set blue_o.
- R11: Windows are consecutive frame pairs counted from the first frame after reset. blue_o clears at the frame_start_i that closes a window containing at least one 0 bit.
- R12: blue_o stays set across a window that contains no 0 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Received bit |
| frame_start_i | input | 1 | Marks the framing bit, the first bit of a frame |
| chan_idx_i | input | 5 | DS0 channel index of bit_i |
| bit_idx_i | input | 3 | Bit index within the channel, 0 first |
| oof_i | input | 1 | Framer out-of-frame flag |
| esf_mode_i | input | 1 | Extended-superframe mode select |
| fdl_valid_i | input | 1 | bit_i is a data-link bit |
| yellow_o | output | 1 | Channel-bit yellow alarm |
| esf_yellow_o | output | 1 | Data-link yellow alarm |
| blue_o | output | 1 | All-ones (AIS) alarm |

## Verification
The hardest state to reach is a blue alarm that is set and then held or cleared at a window edge. Window phase is fixed by the count of frames since reset, so the bench resets, then sends a precise count of all-ones frames with out-of-frame held high. It then places a single zero framing bit in the first frame of a chosen window, so the clear falls exactly two frames later. The data-link clear is also hard to reach: the bench sends exactly 15 and then 16 non-matching bits after a match, with invalid cycles carrying opposite data interleaved.

// File: rtl/ds1_alarm_pkg.sv
package ds1_alarm_pkg;
  localparam int unsigned DS0_PER_FRAME = 24;
  localparam int unsigned DS0_IDX_W     = 5;
  localparam int unsigned DS0_BIT_W     = 3;
  localparam int unsigned FDL_PAT_LEN   = 16;

  typedef struct packed {
    logic yellow;
    logic esf_yellow;
    logic blue;
  } alarm_vec_t;
endpackage

// File: rtl/ds1_yel_det.sv
module ds1_yel_det #(
  parameter int unsigned NUM_CHAN = 24,
  parameter int unsigned CHAN_W   = 5,
  parameter int unsigned BIT_W    = 3,
  parameter int unsigned SIG_POS  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              frame_start_i,
  input  logic [CHAN_W-1:0] chan_idx_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  output logic              yellow_o
);
  localparam int unsigned CNT_W = $clog2(NUM_CHAN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_CHAN);

  logic [CNT_W-1:0] samp_cnt;
  logic             one_seen;
  logic             sample;

  assign sample = !frame_start_i && (bit_idx_i == BIT_W'(SIG_POS))
                  && (32'(chan_idx_i) < NUM_CHAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_cnt <= '0;
      one_seen <= 1'b0;
      yellow_o <= 1'b0;
    end else if (frame_start_i) begin
      // verdict on the frame just ended
      if (one_seen)              yellow_o <= 1'b0;
      else if (samp_cnt == FULL) yellow_o <= 1'b1;
      samp_cnt <= '0;
      one_seen <= 1'b0;
    end else if (sample) begin
      if (samp_cnt != FULL) samp_cnt <= samp_cnt + 1'b1;
      if (bit_i)            one_seen <= 1'b1;
    end
  end

  assert_yel_frame_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(yellow_o));
endmodule

// File: rtl/ds1_esf_yel_det.sv
module ds1_esf_yel_det #(
  parameter int unsigned FDL_LEN = 16,
  parameter int unsigned CLR_RUN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic esf_mode_i,
  input  logic fdl_valid_i,
  output logic esf_yellow_o
);
  localparam int unsigned HALF  = FDL_LEN / 2;
  localparam int unsigned RUN_W = $clog2(CLR_RUN);
  localparam logic [FDL_LEN-1:0] PATTERN = {{HALF{1'b1}}, {(FDL_LEN-HALF){1'b0}}};
  localparam logic [RUN_W-1:0]   RUN_LAST = RUN_W'(CLR_RUN - 1);

  logic [FDL_LEN-1:0] fdl_sr;
  logic [FDL_LEN-1:0] sr_next;
  logic [RUN_W-1:0]   miss_run;
  logic               hit;

  assign sr_next = {fdl_sr[FDL_LEN-2:0], bit_i};
  assign hit     = (sr_next == PATTERN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fdl_sr       <= '0;
      miss_run     <= '0;
      esf_yellow_o <= 1'b0;
    end else if (!esf_mode_i) begin
      fdl_sr       <= '0;
      miss_run     <= '0;
      esf_yellow_o <= 1'b0;
    end else if (fdl_valid_i) begin
      fdl_sr <= sr_next;
      if (hit) begin
        esf_yellow_o <= 1'b1;
        miss_run     <= '0;
      end else if (miss_run == RUN_LAST) begin
        esf_yellow_o <= 1'b0;
        miss_run     <= '0;
      end else begin
        miss_run <= miss_run + 1'b1;
      end
    end
  end

  assert_esf_mode_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !esf_mode_i |=> !esf_yellow_o);
  assert_esf_strobe_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esf_mode_i && !fdl_valid_i) |=> $stable(esf_yellow_o));
endmodule

// File: rtl/ds1_blue_det.sv
module ds1_blue_det #(
  parameter int unsigned NEED_FRAMES = 2,
  parameter int unsigned WIN_FRAMES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic frame_start_i,
  input  logic oof_i,
  output logic blue_o
);
  localparam int unsigned RUN_W = $clog2(NEED_FRAMES + 1);
  localparam int unsigned WIN_W = (WIN_FRAMES > 1) ? $clog2(WIN_FRAMES) : 1;
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(NEED_FRAMES);
  localparam logic [RUN_W-1:0] RUN_ARM  = RUN_W'(NEED_FRAMES - 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_FRAMES - 1);

  logic             started;
  logic             frame_ones;
  logic             frame_oof;
  logic [RUN_W-1:0] run_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic             win_zero;
  logic             frame_hit;
  logic             win_end;

  assign frame_hit = frame_ones && frame_oof;
  assign win_end   = (win_cnt == WIN_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started    <= 1'b0;
      frame_ones <= 1'b0;
      frame_oof  <= 1'b0;
      run_cnt    <= '0;
      win_cnt    <= '0;
      win_zero   <= 1'b0;
      blue_o     <= 1'b0;
    end else if (frame_start_i) begin
      started    <= 1'b1;
      frame_ones <= bit_i;
      frame_oof  <= oof_i;
      if (!started) begin
        win_cnt  <= '0;
        win_zero <= !bit_i;
      end else begin
        if (frame_hit) run_cnt <= (run_cnt == RUN_MAX) ? RUN_MAX : run_cnt + 1'b1;
        else           run_cnt <= '0;
        win_cnt  <= win_end ? '0 : win_cnt + 1'b1;
        win_zero <= win_end ? !bit_i : (win_zero || !bit_i);
        if (frame_hit && run_cnt >= RUN_ARM) blue_o <= 1'b1;
        else if (win_end && win_zero)        blue_o <= 1'b0;
      end
    end else begin
      frame_ones <= frame_ones && bit_i;
      frame_oof  <= frame_oof && oof_i;
      win_zero   <= win_zero || !bit_i;
    end
  end

  assert_blue_needs_oof_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blue_o) |-> ($past(oof_i, 2) && $past(frame_start_i)));
  assert_blue_clear_at_frame_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blue_o) |-> $past(frame_start_i));
endmodule

// File: rtl/ds1_rx_alarm_det.sv
module ds1_rx_alarm_det
  import ds1_alarm_pkg::*;
#(
  parameter int unsigned NUM_CHAN    = DS0_PER_FRAME,
  parameter int unsigned CHAN_W      = DS0_IDX_W,
  parameter int unsigned BIT_W       = DS0_BIT_W,
  parameter int unsigned SIG_POS     = 1,
  parameter int unsigned FDL_LEN     = FDL_PAT_LEN,
  parameter int unsigned CLR_RUN     = FDL_PAT_LEN,
  parameter int unsigned NEED_FRAMES = 2,
  parameter int unsigned WIN_FRAMES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              frame_start_i,
  input  logic [CHAN_W-1:0] chan_idx_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  input  logic              oof_i,
  input  logic              esf_mode_i,
  input  logic              fdl_valid_i,
  output logic              yellow_o,
  output logic              esf_yellow_o,
  output logic              blue_o
);
  alarm_vec_t alarms;

  ds1_yel_det #(
    .NUM_CHAN (NUM_CHAN),
    .CHAN_W   (CHAN_W),
    .BIT_W    (BIT_W),
    .SIG_POS  (SIG_POS)
  ) u_yel (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bit_i         (bit_i),
    .frame_start_i (frame_start_i),
    .chan_idx_i    (chan_idx_i),
    .bit_idx_i     (bit_idx_i),
    .yellow_o      (alarms.yellow)
  );

  ds1_esf_yel_det #(
    .FDL_LEN (FDL_LEN),
    .CLR_RUN (CLR_RUN)
  ) u_esf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_i        (bit_i),
    .esf_mode_i   (esf_mode_i),
    .fdl_valid_i  (fdl_valid_i),
    .esf_yellow_o (alarms.esf_yellow)
  );

  ds1_blue_det #(
    .NEED_FRAMES (NEED_FRAMES),
    .WIN_FRAMES  (WIN_FRAMES)
  ) u_blue (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bit_i         (bit_i),
    .frame_start_i (frame_start_i),
    .oof_i         (oof_i),
    .blue_o        (alarms.blue)
  );

  assign yellow_o     = alarms.yellow;
  assign esf_yellow_o = alarms.esf_yellow;
  assign blue_o       = alarms.blue;
endmodule

// File: tb/ds1_rx_alarm_det_bench.sv
module ds1_rx_alarm_det_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_d, fs, oof, esf, fdl_v;
  logic [4:0] ch;
  logic [2:0] bi;
  logic       yel, esf_yel, blue;
  int         n_vec = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  ds1_rx_alarm_det u_ds1_rx_alarm_det (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_d), .frame_start_i(fs),
    .chan_idx_i(ch), .bit_idx_i(bi), .oof_i(oof), .esf_mode_i(esf),
    .fdl_valid_i(fdl_v), .yellow_o(yel), .esf_yellow_o(esf_yel), .blue_o(blue)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // called at a negedge; holds inputs for one posedge
  task automatic drive(input logic f, input logic d, input logic [4:0] c,
                       input logic [2:0] b, input logic v);
    fs = f; bit_d = d; ch = c; bi = b; fdl_v = v;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fs = 0; bit_d = 1; ch = 0; bi = 0; fdl_v = 0; oof = 0; esf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // bit 1 of every channel = b2, except channel one_ch which carries 1
  task automatic send_frame(input int nch, input logic fbit, input logic pay,
                            input logic b2, input int one_ch);
    drive(1'b1, fbit, 5'd0, 3'd0, 1'b0);
    for (int c = 0; c < nch; c++)
      for (int b = 0; b < 8; b++)
        drive(1'b0, (b == 1) ? ((c == one_ch) ? 1'b1 : b2) : pay, 5'(c), 3'(b), 1'b0);
  endtask

  task automatic fdl_bit(input logic d);
    drive(1'b0, d, 5'd0, 3'd0, 1'b1);
  endtask

  task automatic test_reset();
    do_reset();
    check("R1 yellow", yel, 1'b0);
    check("R1 esf_yellow", esf_yel, 1'b0);
    check("R1 blue", blue, 1'b0);
  endtask

  task automatic test_yellow();
    do_reset();
    send_frame(12, 1, 1, 0, 99);
    send_frame(24, 1, 1, 0, 99);
    check("R4 short frame from clear", yel, 1'b0);
    send_frame(24, 1, 1, 0, 7);
    check("R2 all bit-2 zero sets", yel, 1'b1);
    send_frame(24, 1, 0, 0, 99);
    check("R3 one channel bit-2 one clears", yel, 1'b0);
    send_frame(12, 1, 0, 0, 99);
    check("R2 set again, other bits zero", yel, 1'b1);
    send_frame(24, 1, 1, 1, 99);
    check("R4 short frame holds set", yel, 1'b1);
    send_frame(24, 1, 1, 1, 99);
    check("R3 all ones clears", yel, 1'b0);
  endtask

  task automatic test_esf();
    do_reset();
    esf = 1'b1;
    for (int i = 0; i < 8; i++) fdl_bit(1'b1);
    for (int i = 0; i < 7; i++) fdl_bit(1'b0);
    check("R5 not yet after 15 bits", esf_yel, 1'b0);
    fdl_bit(1'b0);
    check("R5 pattern sets", esf_yel, 1'b1);
    for (int i = 0; i < 8; i++) fdl_bit(1'b1);
    for (int i = 0; i < 8; i++) fdl_bit(1'b0);
    check("R6 repeat holds", esf_yel, 1'b1);
    for (int i = 0; i < 15; i++) fdl_bit(1'b1);
    check("R6 15 misses hold", esf_yel, 1'b1);
    fdl_bit(1'b1);
    check("R6 16th miss clears", esf_yel, 1'b0);
    for (int i = 0; i < 16; i++) begin
      fdl_bit(i < 8);
      drive(1'b0, !(i < 8), 5'd0, 3'd0, 1'b0);
    end
    check("R8 invalid cycles ignored", esf_yel, 1'b1);
    esf = 1'b0;
    drive(1'b0, 1'b0, 5'd0, 3'd0, 1'b0);
    check("R7 mode low clears", esf_yel, 1'b0);
    for (int i = 0; i < 16; i++) fdl_bit(i < 8);
    check("R7 pattern ignored in mode low", esf_yel, 1'b0);
  endtask

  task automatic test_blue();
    do_reset();
    oof = 1'b1;
    send_frame(24, 1, 1, 1, 99);
    send_frame(24, 1, 1, 1, 99);
    check("R9 one frame not enough", blue, 1'b0);
    send_frame(24, 1, 1, 1, 99);
    check("R9 two all-ones frames set", blue, 1'b1);
    send_frame(24, 1, 1, 1, 99);
    send_frame(24, 0, 1, 1, 99);
    check("R12 zero-free window holds", blue, 1'b1);
    send_frame(24, 1, 1, 1, 99);
    check("R11 held until window ends", blue, 1'b1);
    send_frame(24, 1, 1, 1, 99);
    check("R11 window with zero clears", blue, 1'b0);
    do_reset();
    for (int i = 0; i < 4; i++) send_frame(24, 1, 1, 1, 99);
    check("R10 no oof no blue", blue, 1'b0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    test_reset();
    test_yellow();
    test_esf();
    test_blue();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule